// File: doc/BRIEF.md
# Interruptible Repeated Block-Copy Engine

This block copies a block of elements from a source pointer to a destination pointer, one element at a time. Each element is a byte or a 16-bit word. A 16-bit repeat count falls by one for every element that finishes. A direction input picks whether both pointers climb or fall by the element size. All traffic goes over a byte-wide memory port with a ready handshake, so memory can add any number of wait states. Each element costs only its loads and its stores.

A word is always moved as two byte accesses: the low byte at the pointer and the high byte at the pointer plus one. An odd address therefore works exactly like an even one. Between elements the engine samples an interrupt request. If the request is present and elements remain, the engine halts. At that point the count and both pointers describe exactly the elements already copied. A later resume continues from there with the element size and direction latched at start, so no element is lost and none is copied twice.

The controller is a four-state machine. In IDLE it waits and accepts register loads, a start or a resume. In LOAD it reads the element's bytes from the source. In STORE it writes them to the destination. In ADVANCE it updates the count and the pointers and picks the next state. The transitions are:
- IDLE→LOAD on an accepted start or resume with a nonzero count.
- LOAD→STORE when the last byte read is acknowledged.
- STORE→ADVANCE when the last byte write is acknowledged.
- ADVANCE→IDLE when the count reaches zero (done) or when an interrupt request is present (interrupted).
- ADVANCE→LOAD otherwise.

Top module: `strmov_engine`

## Requirements
- R1: After reset the count and both pointers are 0; busy, done, interrupted and mem_req are 0.
- R2: In IDLE with neither start nor resume asserted, ld_en loads rep_count, src_ptr and dst_ptr from ld_count, ld_src and ld_dst. While busy, ld_en is ignored.
- R3: The count drops by exactly 1 as each element finishes. When it reaches 0 the engine returns to idle with done=1. done and interrupted are never 1 together.
- R4: A byte element is one read at src_ptr followed by one write at dst_ptr. A word element (word_mode=1) is a read at src_ptr, a read at src_ptr+1, a write at dst_ptr and a write at dst_ptr+1, with the low byte at the lower address at any alignment. No other accesses occur. Address arithmetic wraps modulo 65536.
- R5: With dir_down=0 both pointers rise by the element size (1 or 2) after each element. With dir_down=1 they fall by it. Both wrap modulo 65536.
- R6: While mem_req=1 and mem_ready=0, mem_addr, mem_we and mem_wdata hold steady into the next cycle.
- R7: irq_req is sampled only in the cycle that finishes an element. If the count after that element is nonzero, the engine stops with busy=0 and interrupted=1. The count and pointers then reflect exactly the elements completed.
- R8: When interrupted=1, a resume pulse continues the copy with the size and direction latched at start. The final memory and registers equal those of an uninterrupted copy. A resume while not interrupted is ignored.
- R9: A start with a count of 0 makes no memory access, and done=1 appears one cycle later.
- R10: A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a copy with the current registers |
| resume | input | 1 | Continue an interrupted copy |
| irq_req | input | 1 | Interrupt request, sampled between elements |
| word_mode | input | 1 | Element size at start: 0 byte, 1 word |
| dir_down | input | 1 | Direction at start: 0 increasing, 1 decreasing |
| ld_en | input | 1 | Load count and pointers while idle |
| ld_count | input | 16 | Count value to load |
| ld_src | input | 16 | Source pointer to load |
| ld_dst | input | 16 | Destination pointer to load |
| rep_count | output | 16 | Remaining element count |
| src_ptr | output | 16 | Source pointer |
| dst_ptr | output | 16 | Destination pointer |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last copy finished with count zero |
| interrupted | output | 1 | Last copy halted by an interrupt request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes on this edge |

## Verification
A lane index stuck at the wrong value or a wrong pointer step shows up on the next access, as an address that departs from the expected sequence. It then shows up at the end as a destination byte in the wrong place. A count or pointer that is updated at the wrong moment is visible at the first interrupted stop: the registers disagree with the number of elements written so far. The sweep covers both sizes, both directions, both alignments of each pointer, pointer wrap, random wait states and random interrupt points, so each such fault appears within a few elements.

// File: rtl/strmov_pkg.sv
package strmov_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STORE,
        ST_ADVANCE
    } strmov_state_e;

    typedef struct packed {
        logic word;
        logic down;
    } strmov_cfg_t;

endpackage

// File: rtl/strmov_step.sv
module strmov_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr,
    input  logic          word,
    input  logic          down,
    input  logic          lane,
    output logic [AW-1:0] next_ptr,
    output logic [AW-1:0] lane_addr
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] TWO = ONE << 1;

    logic [AW-1:0] size;

    always_comb begin
        size      = word ? TWO : ONE;
        next_ptr  = down ? (ptr - size) : (ptr + size);
        lane_addr = ptr + {{(AW-1){1'b0}}, lane};
    end
endmodule

// File: rtl/strmov_engine.sv
module strmov_engine
    import strmov_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          resume,
    input  logic          irq_req,
    input  logic          word_mode,
    input  logic          dir_down,
    input  logic          ld_en,
    input  logic [CW-1:0] ld_count,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_dst,
    output logic [CW-1:0] rep_count,
    output logic [AW-1:0] src_ptr,
    output logic [AW-1:0] dst_ptr,
    output logic          busy,
    output logic          done,
    output logic          interrupted,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);
    localparam int LANES = 2;
    localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

    strmov_state_e state_q, state_d;
    strmov_cfg_t   cfg_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] src_q, dst_q;
    logic          lane_q;
    logic [DW-1:0] buf_q [LANES];
    logic          done_q, intr_q;

    logic [AW-1:0] src_next, dst_next, src_lane, dst_lane;
    logic          last_lane, cnt_zero, go_start, go_resume;

    strmov_step #(.AW(AW)) u_src_step (
        .ptr(src_q), .word(cfg_q.word), .down(cfg_q.down), .lane(lane_q),
        .next_ptr(src_next), .lane_addr(src_lane)
    );

    strmov_step #(.AW(AW)) u_dst_step (
        .ptr(dst_q), .word(cfg_q.word), .down(cfg_q.down), .lane(lane_q),
        .next_ptr(dst_next), .lane_addr(dst_lane)
    );

    assign last_lane = !cfg_q.word || lane_q;
    assign cnt_zero  = (cnt_q == '0);
    assign go_start  = (state_q == ST_IDLE) && start;
    assign go_resume = (state_q == ST_IDLE) && !start && resume && intr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if ((go_start || go_resume) && !cnt_zero) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (mem_ready && last_lane) state_d = ST_STORE;
            end
            ST_STORE: begin
                if (mem_ready && last_lane) state_d = ST_ADVANCE;
            end
            ST_ADVANCE: begin
                if (cnt_q == CNT_ONE || irq_req) state_d = ST_IDLE;
                else                             state_d = ST_LOAD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        unique case (state_q)
            ST_LOAD: begin
                mem_req  = 1'b1;
                mem_addr = src_lane;
            end
            ST_STORE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_lane;
            end
            default: ;
        endcase
        mem_wdata   = buf_q[lane_q];
        busy        = (state_q != ST_IDLE);
        done        = done_q;
        interrupted = intr_q;
        rep_count   = cnt_q;
        src_ptr     = src_q;
        dst_ptr     = dst_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            cnt_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            lane_q <= 1'b0;
            done_q <= 1'b0;
            intr_q <= 1'b0;
            for (int i = 0; i < LANES; i++) buf_q[i] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go_start) begin
                        cfg_q  <= '{word: word_mode, down: dir_down};
                        lane_q <= 1'b0;
                        done_q <= cnt_zero;
                        intr_q <= 1'b0;
                    end else if (go_resume) begin
                        lane_q <= 1'b0;
                        done_q <= cnt_zero;
                        intr_q <= 1'b0;
                    end else if (ld_en && !resume) begin
                        cnt_q <= ld_count;
                        src_q <= ld_src;
                        dst_q <= ld_dst;
                    end
                end
                ST_LOAD: begin
                    if (mem_ready) begin
                        buf_q[lane_q] <= mem_rdata;
                        lane_q        <= !last_lane;
                    end
                end
                ST_STORE: begin
                    if (mem_ready) lane_q <= !last_lane;
                end
                ST_ADVANCE: begin
                    cnt_q  <= cnt_q - CNT_ONE;
                    src_q  <= src_next;
                    dst_q  <= dst_next;
                    lane_q <= 1'b0;
                    if (cnt_q == CNT_ONE) done_q <= 1'b1;
                    else if (irq_req)     intr_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/strmov_engine_chk.sv
module strmov_engine_chk #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          interrupted,
    input logic [CW-1:0] rep_count,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready
);
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (rep_count == $past(rep_count)) || (rep_count == $past(rep_count) - 1'b1));

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && interrupted));

    a_r3_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (rep_count == '0) && !busy);

    a_r4_access_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r7_stop_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(interrupted) |-> (rep_count != '0) && !busy);
endmodule

bind strmov_engine strmov_engine_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .interrupted(interrupted),
    .rep_count(rep_count), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/test_strmov_engine.sv
module test_strmov_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, resume = 1'b0, irq_req = 1'b0;
    logic        word_mode = 1'b0, dir_down = 1'b0, ld_en = 1'b0;
    logic [15:0] ld_count = '0, ld_src = '0, ld_dst = '0;
    logic [15:0] rep_count, src_ptr, dst_ptr, mem_addr;
    logic        busy, done, interrupted, mem_req, mem_we, mem_ready = 1'b1;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0]  mem [4096];
    logic [15:0] lfsr = 16'hACE1;
    int          wait_mode = 0, irq_mode = 0;
    int          g_sz = 1;
    bit          g_dn = 1'b0;
    logic [15:0] g_s0 = '0, g_d0 = '0;
    int          acc_cnt = 0, acc_err = 0, wr_bytes = 0;
    int          n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:0]];

    strmov_engine i_strmov_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .resume(resume), .irq_req(irq_req),
        .word_mode(word_mode), .dir_down(dir_down), .ld_en(ld_en),
        .ld_count(ld_count), .ld_src(ld_src), .ld_dst(ld_dst),
        .rep_count(rep_count), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
        .busy(busy), .done(done), .interrupted(interrupted),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [15:0] offa(logic [15:0] b, int k, int j, int sz, bit dn);
        int v;
        v = dn ? (int'(b) - k*sz + j) : (int'(b) + k*sz + j);
        return v[15:0];
    endfunction

    function automatic logic [7:0] pat(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model, wait states, interrupt stimulus and access monitor (R4, R6)
    always @(negedge clk) begin
        int k, p;
        logic [15:0] ea;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_ready = (wait_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
        irq_req   = (irq_mode == 1) ? 1'b1 : (irq_mode == 2) ? (lfsr[5] & lfsr[7]) : 1'b0;
        if (mem_req && mem_ready) begin
            k = acc_cnt / (2*g_sz);
            p = acc_cnt % (2*g_sz);
            if (p < g_sz) ea = offa(g_s0, k, p, g_sz, g_dn);
            else          ea = offa(g_d0, k, p - g_sz, g_sz, g_dn);
            if (mem_addr != ea || mem_we != (p >= g_sz)) acc_err++;
            if (mem_we) begin
                mem[mem_addr[11:0]] = mem_wdata;
                wr_bytes++;
            end
            acc_cnt++;
        end
    end

    task automatic load_regs(logic [15:0] c, logic [15:0] s, logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_count = c; ld_src = s; ld_dst = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_copy(int sz, bit dn, logic [15:0] s0, logic [15:0] d0,
                            int n, int irqm, int waitm, bit disturb);
        int stops = 0, guard = 0, bad = 0, comp;
        logic [15:0] a;
        g_sz = sz; g_dn = dn; g_s0 = s0; g_d0 = d0;
        acc_cnt = 0; acc_err = 0; wr_bytes = 0;
        wait_mode = waitm; irq_mode = irqm;
        for (int k = 0; k < n; k++)
            for (int j = 0; j < sz; j++) begin
                a = offa(s0, k, j, sz, dn);
                mem[a[11:0]] = pat(a);
                a = offa(d0, k, j, sz, dn);
                mem[a[11:0]] = 8'h00;
            end
        load_regs(16'(n), s0, d0);
        word_mode = (sz == 2); dir_down = dn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R2 and R10: loads and a second start while busy are ignored
            ld_en = 1'b1; ld_count = 16'h1234; ld_src = 16'h0BAD; ld_dst = 16'h0F00;
            start = 1'b1; word_mode = ~word_mode; dir_down = ~dir_down;
            @(negedge clk);
            ld_en = 1'b0; start = 1'b0;
        end
        while (guard < 20000) begin
            guard++;
            if (!busy) begin
                if (interrupted) begin
                    stops++;
                    comp = wr_bytes / sz;
                    chk(rep_count == 16'(n - comp), "R7", "count at stop", rep_count, n - comp);
                    chk(src_ptr == offa(s0, comp, 0, sz, dn), "R7", "src at stop",
                        src_ptr, offa(s0, comp, 0, sz, dn));
                    chk(dst_ptr == offa(d0, comp, 0, sz, dn) && !done, "R7", "dst at stop",
                        dst_ptr, offa(d0, comp, 0, sz, dn));
                    resume = 1'b1;
                    @(negedge clk);
                    resume = 1'b0;
                    continue;
                end
                break;
            end
            @(negedge clk);
        end
        irq_mode = 0;
        chk(done && !interrupted, "R3", "done flag", done, 1);
        chk(rep_count == 16'd0, "R3", "final count", rep_count, 0);
        chk(src_ptr == offa(s0, n, 0, sz, dn), "R5", "final src", src_ptr, offa(s0, n, 0, sz, dn));
        chk(dst_ptr == offa(d0, n, 0, sz, dn), "R5", "final dst", dst_ptr, offa(d0, n, 0, sz, dn));
        chk(acc_err == 0 && acc_cnt == 2*n*sz, "R4", "access sequence", acc_cnt, 2*n*sz);
        for (int k = 0; k < n; k++)
            for (int j = 0; j < sz; j++) begin
                a = offa(d0, k, j, sz, dn);
                if (mem[a[11:0]] != pat(offa(s0, k, j, sz, dn))) bad++;
            end
        chk(bad == 0, (irqm != 0) ? "R8" : "R6", "dest bytes wrong", bad, 0);
        if (irqm == 1) chk(stops == n - 1, "R7", "stop count", stops, n - 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL R3 watchdog expired actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base_acc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rep_count == 0 && src_ptr == 0 && dst_ptr == 0, "R1", "regs after reset", rep_count, 0);
        chk(!busy && !done && !interrupted && !mem_req, "R1", "flags after reset",
            {busy, done, interrupted, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 load while idle
        load_regs(16'h0007, 16'h1357, 16'h2468);
        chk(rep_count == 16'h0007 && src_ptr == 16'h1357 && dst_ptr == 16'h2468,
            "R2", "idle load", src_ptr, 16'h1357);

        // R9 zero count
        load_regs(16'h0000, 16'h1234, 16'h4321);
        acc_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy, "R9", "zero count done", done, 1);
        repeat (3) @(negedge clk);
        chk(acc_cnt == 0 && src_ptr == 16'h1234, "R9", "zero count accesses", acc_cnt, 0);

        // sweep: size, direction, alignments, interrupt mode, wait mode
        for (int sz = 1; sz <= 2; sz++)
            for (int dn = 0; dn <= 1; dn++)
                for (int sa = 0; sa <= 1; sa++)
                    for (int da = 0; da <= 1; da++)
                        for (int im = 0; im <= 2; im++)
                            for (int wm = 0; wm <= 1; wm++) begin
                                if (dn == 0)
                                    run_copy(sz, 1'b0, 16'(16'hFFF8 + sa), 16'(16'h4100 + da),
                                             5, im, wm, (im == 0 && wm == 1));
                                else
                                    run_copy(sz, 1'b1, 16'(16'h0006 + sa), 16'(16'h8100 + da),
                                             5, im, wm, (im == 0 && wm == 1));
                            end

        // longer blocks with random interrupts and waits
        run_copy(1, 1'b0, 16'h0201, 16'h0600, 40, 2, 1, 1'b0);
        run_copy(2, 1'b1, 16'h0901, 16'h0E00, 30, 2, 1, 1'b0);

        // R8 resume ignored when not interrupted
        base_acc = acc_cnt;
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        @(negedge clk);
        chk(!busy && acc_cnt == base_acc && done, "R8", "stray resume", busy, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule